// File: doc/BRIEF.md
# Bus Interrupt Request Priority Resolver

This block sits between the interrupt request lines of a legacy expansion bus and a processor. Eleven of sixteen line positions exist on the bus: 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15. Each existing line is brought through a synchronizer. A low-to-high transition on a line records a pending request. The request stays recorded until the processor acknowledges it by vector number.

Among the pending requests that are enabled, the block presents one to the processor. It uses a fixed order that is not numeric: the upper group 9, 10, 11, 12, 14, 15 outranks the lower group 3, 4, 5, 6, 7. Line 9 ranks first and line 7 ranks last. A simple per-line enable mask can hide a pending request without discarding it.

Because capture is on edges, a line that is still held high after its acknowledge raises nothing new. It must fall and rise again before it can request a second time.

Top module: `irq_prio_resolver`

## Requirements
- R1: A rising edge on an existing line sets that line's pending bit. With the default two synchronizer stages, a line driven high ahead of clock edge n shows on `irq_out` and `irq_vector` right after edge n+2. It does not show any earlier.
- R2: A line held high after its acknowledge does not set its pending bit again. It must go low and then high again to request a second time.
- R3: `irq_vector` names the enabled pending line of highest rank. The ranks run 9, 10, 11, 12, 14, 15, 3, 4, 5, 6, 7, with line 9 highest and line 7 lowest. The value is the line number as 4-bit binary.
- R4: Line positions 0, 1, 2, 8 and 13 of `irq_lines` are ignored. They never become pending and are never named on `irq_vector`.
- R5: An edge with `ack_valid` high clears the pending bit of the line numbered `ack_vector`, and clears no other bit. An acknowledge naming a line that is not pending changes nothing.
- R6: An acknowledge and a new rising edge for the same line at the same clock edge leave that line pending.
- R7: `mask_data` bit k enables line k. A clock edge with `mask_wr` high loads the whole mask. A masked line keeps its pending bit but is not presented, and it is presented again once it is unmasked.
- R8: Reset (`rst_n` low) clears all pending bits and enables every line. During reset, `irq_out` is 0 and `irq_vector` is 0.
- R9: `irq_out` is 1 exactly when some line is both pending and enabled. While `irq_out` is 0, `irq_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 16 | Request lines, bit k is line k; asynchronous |
| mask_wr | input | 1 | Load the enable mask from `mask_data` |
| mask_data | input | 16 | New enable mask, bit k enables line k |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vector | input | 4 | Line number being acknowledged |
| irq_out | output | 1 | Some enabled request is pending |
| irq_vector | output | 4 | Line number of the winning request |

## Verification
The hardest situation to reach is a new rising edge arriving at the very clock edge that acknowledges the same line (R6). To get there, the stimulus first drops a pending line, then raises it again. It counts the synchronizer stages and raises `ack_valid` for exactly the cycle in which the edge matures. A second subtle case is the held-high line after acknowledge (R2). The stimulus keeps the line high across many cycles and then checks that nothing comes back until the line has cycled low and high.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_lines,
  input  logic        mask_wr,
  input  logic [15:0] mask_data,
  input  logic        ack_valid,
  input  logic [3:0]  ack_vector,
  output logic        irq_out,
  output logic [3:0]  irq_vector
);
  localparam logic [15:0] BUS_LINES = 16'hDEF8;
  localparam int NRANKS = 11;

  logic [15:0] sync_q [SYNC_STAGES];
  logic [15:0] last_q, pend_q, en_q, rise, ack_hit, live;
  logic [3:0]  win;

  function automatic logic [3:0] line_of(input int k);
    if (k < 4)      return 4'(9 + k);
    else if (k < 6) return 4'(10 + k);
    else            return 4'(k - 3);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      last_q <= '0;
    end else begin
      sync_q[0] <= irq_lines;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise    = sync_q[SYNC_STAGES-1] & ~last_q & BUS_LINES;
  assign ack_hit = ack_valid ? (16'd1 << ack_vector) : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '1;
    end else begin
      pend_q <= (pend_q & ~ack_hit) | rise;
      if (mask_wr) en_q <= mask_data;
    end
  end

  assign live = pend_q & en_q;

  always_comb begin
    win = '0;
    for (int k = NRANKS - 1; k >= 0; k--)
      if (live[line_of(k)]) win = line_of(k);
  end

  assign irq_out    = |live;
  assign irq_vector = win;

  AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> irq_vector == 4'd0); // R9
  AST_ONLY_BUS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~BUS_LINES) == 16'd0); // R4
  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_q[irq_vector] && en_q[irq_vector])); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !rise[ack_vector]) |=> !pend_q[$past(ack_vector)]); // R5
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise))); // R1
  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~ack_hit)) == $past(pend_q & ~ack_hit))); // R5
endmodule

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] irq_lines = '0;
  logic        mask_wr = 0;
  logic [15:0] mask_data = '0;
  logic        ack_valid = 0;
  logic [3:0]  ack_vector = '0;
  logic        irq_out;
  logic [3:0]  irq_vector;

  irq_prio_resolver u_irq_prio_resolver (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .mask_wr(mask_wr),
    .mask_data(mask_data), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .irq_out(irq_out), .irq_vector(irq_vector));

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit started = 0;
  string tag = "R8";

  // behavioural reference
  logic [15:0] hist [$];
  logic [15:0] m_pend = '0, m_mask = '1;
  int order [11] = '{9, 10, 11, 12, 14, 15, 3, 4, 5, 6, 7};
  initial hist = '{16'h0, 16'h0, 16'h0};

  always @(posedge clk) begin
    logic [15:0] r;
    if (!rst_n) begin
      hist = '{16'h0, 16'h0, 16'h0};
      m_pend = '0;
      m_mask = '1;
    end else begin
      r = hist[1] & ~hist[2];
      if (ack_valid) m_pend[ack_vector] = 1'b0;
      for (int i = 0; i < 11; i++)
        if (r[order[i]]) m_pend[order[i]] = 1'b1;
      if (mask_wr) m_mask = mask_data;
      hist.push_front(irq_lines);
      void'(hist.pop_back());
    end
  end

  function automatic void model_out(output logic e_irq, output logic [3:0] e_vec);
    e_irq = 0;
    e_vec = 0;
    for (int i = 0; i < 11; i++)
      if (!e_irq && m_pend[order[i]] && m_mask[order[i]]) begin
        e_irq = 1;
        e_vec = 4'(order[i]);
      end
  endfunction

  task automatic compare();
    logic ei;
    logic [3:0] ev;
    model_out(ei, ev);
    vectors++;
    if (irq_out !== ei || irq_vector !== ev) begin
      fails++;
      $display("FAIL %s: irq_out=%0b irq_vector=%0d expected irq_out=%0b irq_vector=%0d",
               tag, irq_out, irq_vector, ei, ev);
    end
  endtask

  task automatic chk(input string req, input logic ei, input logic [3:0] ev);
    vectors++;
    if (irq_out !== ei || irq_vector !== ev) begin
      fails++;
      $display("FAIL %s: irq_out=%0b irq_vector=%0d expected irq_out=%0b irq_vector=%0d",
               req, irq_out, irq_vector, ei, ev);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (started) compare();
    end
  endtask

  task automatic ack(input logic [3:0] v);
    ack_valid = 1; ack_vector = v;
    tick();
    ack_valid = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    started = 1;
    tick(3);
    chk("R8", 0, 0);
    rst_n = 1;
    tick();

    tag = "R1";
    irq_lines[5] = 1;
    tick(2);
    chk("R1", 0, 0);
    tick();
    chk("R1", 1, 5);

    tag = "R3";
    irq_lines[3] = 1; irq_lines[15] = 1;
    tick(3);
    chk("R3", 1, 15);
    irq_lines[9] = 1;
    tick(3);
    chk("R3", 1, 9);

    tag = "R5";
    ack(9);
    chk("R5", 1, 15);
    ack(2);
    chk("R5", 1, 15);

    tag = "R2";
    ack(15);
    tick(5);
    chk("R2", 1, 3);
    irq_lines[15] = 0;
    tick(3);
    irq_lines[15] = 1;
    tick(3);
    chk("R2", 1, 15);

    tag = "R4";
    irq_lines[0] = 1; irq_lines[1] = 1; irq_lines[2] = 1;
    irq_lines[8] = 1; irq_lines[13] = 1;
    ack(15); ack(3); ack(5);
    tick(4);
    chk("R4", 0, 0);
    chk("R9", 0, 0);

    tag = "R7";
    mask_wr = 1; mask_data = ~16'h0010;
    tick();
    mask_wr = 0;
    irq_lines[4] = 1;
    tick(4);
    chk("R7", 0, 0);
    mask_wr = 1; mask_data = 16'hFFFF;
    tick();
    mask_wr = 0;
    chk("R7", 1, 4);

    tag = "R6";
    irq_lines[4] = 0;
    tick(3);
    irq_lines[4] = 1;
    tick(2);
    ack(4);
    chk("R6", 1, 4);
    ack(4);
    chk("R5", 0, 0);

    tag = "R3";
    for (int c = 0; c < 3000; c++) begin
      for (int b = 0; b < 16; b++)
        if ($urandom_range(15) == 0) irq_lines[b] = ~irq_lines[b];
      ack_valid = ($urandom_range(3) == 0);
      ack_vector = irq_out ? irq_vector : 4'($urandom_range(15));
      mask_wr = ($urandom_range(49) == 0);
      mask_data = 16'($urandom);
      tick();
    end
    ack_valid = 0; mask_wr = 0;

    tag = "R8";
    rst_n = 0;
    tick();
    chk("R8", 0, 0);
    rst_n = 1;
    tick(2);
    finish_run();
  end
endmodule